// File: doc/BRIEF.md
# Interrupt Request and Masking Unit

This block gathers every interrupt source of a small 8-bit processor core and decides which request is offered to the core. There are three kinds of source. A one-cycle software-interrupt strobe arrives from the instruction sequencer. An active-low, level-sensitive external request line can be shared by several open-drain devices. A set of internal peripheral events each raises its own flag. The block also receives the global interrupt mask bit from the core's condition code register. From these it produces a pending indication, the index of the winning source, and a one-cycle request to set the mask bit once the core begins servicing.

Software reads the peripheral flags and their enable bits on two output buses and changes them through a write strobe with a one-bit register select. Select 0 loads the enable register. Select 1 clears flags: each 1 bit in the data clears the matching flag. A small state machine tracks the start of service. It has two states. `ST_IDLE` is the resting state. `ST_ENTER` is held for the single cycle that follows an accepted take and drives the mask-set request. There are three transitions. IDLE goes to ENTER on an accepted take. ENTER stays in ENTER on a further accepted take. ENTER returns to IDLE otherwise.

Top module: `irq_gate_unit`

## Requirements
- R1: A `swi_i` strobe latches a software request. From the next cycle it keeps `pend_o` high whatever the value of `cc_mask_i`. It stays latched until a take is accepted while `vec_o` is 0.
- R2: A take is accepted when `take_i` and `pend_o` are both high. `set_mask_o` is high in the cycle after each accepted take and low otherwise. A take while `pend_o` is low is ignored.
- R3: While `cc_mask_i` is 0, a low level on `ext_n_i` is a request. A high level, or a mask of 1, removes the external line's contribution.
- R4: A high bit of `evt_i` sets the matching bit of `flag_o` from the next cycle. While the flag, its enable bit and a clear mask are all present, that source requests service.
- R5: A write with `wr_sel_i`=1 clears each flag whose `wr_data_i` bit is 1. The flag and its request are gone in the next cycle. Data bits of 0 leave flags unchanged.
- R6: A write with `wr_sel_i`=0 loads `wr_data_i` into the enable bits, which appear on `en_o` in the next cycle.
- R7: The priority order is fixed. `vec_o` is 0 for the software request, 1 for the external line, and 2+k for peripheral k. Among peripherals the lowest k wins.
- R8: When an event and a clear hit the same flag in the same cycle, the flag is set afterwards.
- R9: `pend_o` is the OR of the latched software request and every enabled, unmasked request.
- R10: After reset the flags, the enables, the software latch and `set_mask_o` are all 0, and the state machine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swi_i | input | 1 | Software-interrupt strobe |
| ext_n_i | input | 1 | Active-low shared external request line |
| evt_i | input | N_SRC | Peripheral event pulses |
| cc_mask_i | input | 1 | Global interrupt mask bit from the core |
| take_i | input | 1 | Core begins servicing the offered vector |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: enable register, 1: flag clear |
| wr_data_i | input | N_SRC | Write data |
| pend_o | output | 1 | An interrupt is pending |
| vec_o | output | VW | Index of the winning source |
| set_mask_o | output | 1 | Request to set the global mask bit |
| flag_o | output | N_SRC | Peripheral flags |
| en_o | output | N_SRC | Peripheral enable bits |

## Verification
Two pairs of functions can act in the same cycle. A peripheral event can arrive in the cycle that software clears the same flag. An accepted take of the software vector can coincide with a fresh `swi_i` strobe. The bench forces the first pair in a directed cycle and then checks that the flag is still set. Random traffic with dense events, clear writes and takes reaches both pairs many times. A bench model applies set-before-clear ordering, and every cycle the flags, `pend_o` and `vec_o` are compared with that model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ENTER = 1'b1
    } entry_st_t;

    localparam logic WSEL_ENABLE = 1'b0;
    localparam logic WSEL_CLEAR  = 1'b1;

    localparam int VEC_SWI      = 0;
    localparam int VEC_EXT      = 1;
    localparam int VEC_PER_BASE = 2;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_gate_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] en_o
);

    logic [N_SRC-1:0] clr_vec;
    logic             en_wr;

    assign clr_vec = (wr_en_i && (wr_sel_i == WSEL_CLEAR)) ? wr_data_i : '0;
    assign en_wr   = wr_en_i && (wr_sel_i == WSEL_ENABLE);

    // One flag cell per source: a set takes precedence over a clear
    for (genvar k = 0; k < N_SRC; k++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_o[k] <= 1'b0;
            end else if (evt_i[k]) begin
                flag_o[k] <= 1'b1;
            end else if (clr_vec[k]) begin
                flag_o[k] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (en_wr) begin
            en_o <= wr_data_i;
        end
    end

    // R5: a clear with no event removes the flag
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> ((flag_o & $past(wr_data_i & ~evt_i)) == '0));

    // R8: an event always leaves its flag set
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

    // R6: the enable register takes the written value
    a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (en_o == $past(wr_data_i)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_gate_pkg::*;
#(
    parameter  int N_SRC = 4,
    localparam int VW    = $clog2(N_SRC + 2)
) (
    input  logic             swi_req_i,
    input  logic             ext_req_i,
    input  logic [N_SRC-1:0] per_req_i,
    output logic             any_o,
    output logic [VW-1:0]    idx_o
);

    always_comb begin
        idx_o = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (per_req_i[k]) begin
                idx_o = VW'(VEC_PER_BASE + k);
            end
        end
        if (ext_req_i) begin
            idx_o = VW'(VEC_EXT);
        end
        if (swi_req_i) begin
            idx_o = VW'(VEC_SWI);
        end
    end

    assign any_o = swi_req_i | ext_req_i | (|per_req_i);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_gate_pkg::*;
#(
    parameter int VW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swi_i,
    input  logic          take_i,
    input  logic          pend_i,
    input  logic [VW-1:0] vec_i,
    output logic          swi_pend_o,
    output logic          set_mask_o
);

    entry_st_t state_q, state_d;
    logic      accept;
    logic      swi_taken;

    assign accept    = take_i && pend_i;
    assign swi_taken = accept && (vec_i == VW'(VEC_SWI));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_ENTER : ST_IDLE;
            ST_ENTER: state_d = accept ? ST_ENTER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        set_mask_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  set_mask_o = 1'b0;
            ST_ENTER: set_mask_o = 1'b1;
            default:  set_mask_o = 1'b0;
        endcase
    end

    // Software request latch: a new strobe wins over a take
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swi_pend_o <= 1'b0;
        end else if (swi_i) begin
            swi_pend_o <= 1'b1;
        end else if (swi_taken) begin
            swi_pend_o <= 1'b0;
        end
    end

    // R2: each accepted take is followed by a mask-set request
    a_r2_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pend_i) |=> set_mask_o);

    // R2: no mask-set request without an accepted take
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i && pend_i) |=> !set_mask_o);

    // R1: the software latch holds until its own vector is taken
    a_r1_swi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_pend_o && !(take_i && pend_i && vec_i == VW'(VEC_SWI))) |=> swi_pend_o);

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
    import irq_gate_pkg::*;
#(
    parameter  int N_SRC = 4,
    localparam int VW    = $clog2(N_SRC + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swi_i,
    input  logic             ext_n_i,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             cc_mask_i,
    input  logic             take_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic             pend_o,
    output logic [VW-1:0]    vec_o,
    output logic             set_mask_o,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] en_o
);

    logic             swi_pend;
    logic             ext_req;
    logic [N_SRC-1:0] per_req;

    irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .flag_o    (flag_o),
        .en_o      (en_o)
    );

    assign ext_req = !ext_n_i && !cc_mask_i;
    assign per_req = flag_o & en_o & {N_SRC{!cc_mask_i}};

    irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .swi_req_i (swi_pend),
        .ext_req_i (ext_req),
        .per_req_i (per_req),
        .any_o     (pend_o),
        .idx_o     (vec_o)
    );

    irq_entry_fsm #(.VW(VW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .swi_i      (swi_i),
        .take_i     (take_i),
        .pend_i     (pend_o),
        .vec_i      (vec_o),
        .swi_pend_o (swi_pend),
        .set_mask_o (set_mask_o)
    );

    // R1: a software strobe raises pending in the next cycle, masked or not
    a_r1_swi_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        swi_i |=> pend_o);

    // R3: with the mask set only the software latch can raise pending
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cc_mask_i |-> (pend_o == swi_pend));

    // R7: the software request always has the top index
    a_r7_swi_first: assert property (@(posedge clk) disable iff (!rst_n)
        swi_pend |-> (vec_o == VW'(VEC_SWI)));

    // R7: an unmasked external request beats every peripheral
    a_r7_ext_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!swi_pend && !ext_n_i && !cc_mask_i) |-> (vec_o == VW'(VEC_EXT)));

endmodule

// File: tb/irq_gate_unit_tb.sv
`timescale 1ns/1ps
module irq_gate_unit_tb;

    localparam int N  = 4;
    localparam int VW = $clog2(N + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          swi_i = 1'b0;
    logic          ext_n_i = 1'b1;
    logic [N-1:0]  evt_i = '0;
    logic          cc_mask_i = 1'b0;
    logic          take_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic          wr_sel_i = 1'b0;
    logic [N-1:0]  wr_data_i = '0;
    logic          pend_o;
    logic [VW-1:0] vec_o;
    logic          set_mask_o;
    logic [N-1:0]  flag_o;
    logic [N-1:0]  en_o;

    always #2 clk = ~clk;

    irq_gate_unit #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .swi_i(swi_i), .ext_n_i(ext_n_i),
        .evt_i(evt_i), .cc_mask_i(cc_mask_i), .take_i(take_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .pend_o(pend_o), .vec_o(vec_o), .set_mask_o(set_mask_o),
        .flag_o(flag_o), .en_o(en_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // staged stimulus for the next cycle
    bit         s_swi, s_ext_n, s_mask, s_take, s_wr, s_sel;
    bit [N-1:0] s_evt, s_data;

    // reference model state
    bit [N-1:0] m_flag = '0;
    bit [N-1:0] m_en   = '0;
    bit         m_swi  = 1'b0;
    bit         m_sm   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_pend();
        bit ext_r;
        ext_r = !s_ext_n && !s_mask;
        return m_swi || ext_r || ((m_flag & m_en) != '0 && !s_mask);
    endfunction

    function automatic int m_vec();
        if (m_swi) return 0;
        if (!s_ext_n && !s_mask) return 1;
        for (int k = 0; k < N; k++) begin
            if (m_flag[k] && m_en[k] && !s_mask) return 2 + k;
        end
        return 0;
    endfunction

    task automatic idle_stage();
        s_swi = 0; s_ext_n = 1; s_mask = 0; s_take = 0;
        s_wr = 0; s_sel = 0; s_evt = '0; s_data = '0;
    endtask

    task automatic drive();
        @(negedge clk);
        swi_i = s_swi; ext_n_i = s_ext_n; cc_mask_i = s_mask; take_i = s_take;
        wr_en_i = s_wr; wr_sel_i = s_sel; evt_i = s_evt; wr_data_i = s_data;
        #1;
        chk(pend_o === m_pend(), "R9", "pend_o", int'(pend_o), int'(m_pend()));
        if (m_pend()) chk(int'(vec_o) == m_vec(), "R7", "vec_o", int'(vec_o), m_vec());
        chk(set_mask_o === m_sm, "R2", "set_mask_o", int'(set_mask_o), int'(m_sm));
        chk(flag_o === m_flag, "R4", "flag_o", int'(flag_o), int'(m_flag));
        chk(en_o === m_en, "R6", "en_o", int'(en_o), int'(m_en));
    endtask

    task automatic tick();
        bit         acc;
        int         v;
        bit [N-1:0] clrv;
        @(posedge clk);
        acc  = s_take && m_pend();
        v    = m_vec();
        clrv = (s_wr && s_sel) ? s_data : '0;
        m_swi  = s_swi || (m_swi && !(acc && v == 0));
        m_sm   = acc;
        m_flag = (m_flag & ~clrv) | s_evt;
        if (s_wr && !s_sel) m_en = s_data;
    endtask

    task automatic cyc();
        drive();
        tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        idle_stage();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        drive();
        chk(flag_o == '0 && en_o == '0, "R10", "flags/enables", int'({flag_o, en_o}), 0);
        chk(!pend_o && !set_mask_o, "R10", "pend/set_mask", int'({pend_o, set_mask_o}), 0);
        tick();

        // R6: enable all sources
        idle_stage(); s_wr = 1; s_sel = 0; s_data = '1; cyc();

        // R4: an event sets its flag and requests service
        idle_stage(); s_evt = 4'b0001; cyc();
        idle_stage(); drive();
        chk(pend_o && vec_o == 3'd2, "R4", "pend/vec after event", int'(vec_o), 2);
        tick();

        // R8: event and clear on the same flag in the same cycle
        idle_stage(); s_evt = 4'b0001; s_wr = 1; s_sel = 1; s_data = 4'b0001; cyc();
        idle_stage(); drive();
        chk(flag_o[0] == 1'b1, "R8", "flag0 after set+clear", int'(flag_o[0]), 1);
        tick();

        // R5: writing 0 leaves the flag, writing 1 clears it
        idle_stage(); s_wr = 1; s_sel = 1; s_data = 4'b0000; cyc();
        idle_stage(); drive();
        chk(flag_o[0] == 1'b1, "R5", "flag0 after zero write", int'(flag_o[0]), 1);
        tick();
        idle_stage(); s_wr = 1; s_sel = 1; s_data = 4'b0001; cyc();
        idle_stage(); drive();
        chk(flag_o[0] == 1'b0 && !pend_o, "R5", "flag0/pend after clear",
            int'({flag_o[0], pend_o}), 0);
        tick();

        // R3: external line is masked, then seen
        idle_stage(); s_ext_n = 0; s_mask = 1; drive();
        chk(!pend_o, "R3", "pend with mask set", int'(pend_o), 0);
        tick();
        idle_stage(); s_ext_n = 0; s_mask = 0; drive();
        chk(pend_o && vec_o == 3'd1, "R3", "vec for external", int'(vec_o), 1);
        tick();

        // R1: software strobe under mask, then taken
        idle_stage(); s_mask = 1; s_swi = 1; cyc();
        idle_stage(); s_mask = 1; drive();
        chk(pend_o && vec_o == 3'd0, "R1", "swi pending under mask", int'(pend_o), 1);
        tick();
        idle_stage(); s_mask = 1; s_take = 1; cyc();
        idle_stage(); s_mask = 1; drive();
        chk(set_mask_o, "R2", "set_mask after take", int'(set_mask_o), 1);
        chk(!pend_o, "R1", "swi latch cleared after take", int'(pend_o), 0);
        tick();

        // R7: peripherals 1 and 3 pending, lowest index wins
        idle_stage(); s_evt = 4'b1010; cyc();
        idle_stage(); drive();
        chk(vec_o == 3'd3, "R7", "lowest peripheral wins", int'(vec_o), 3);
        tick();
        idle_stage(); s_wr = 1; s_sel = 1; s_data = '1; cyc();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            s_swi   = ($urandom % 8) == 0;
            s_ext_n = ($urandom % 3) != 0;
            s_mask  = ($urandom % 2) == 0;
            s_take  = ($urandom % 4) == 0;
            s_wr    = ($urandom % 3) == 0;
            s_sel   = ($urandom % 2) == 0;
            s_evt   = N'($urandom & $urandom & $urandom);
            s_data  = N'($urandom);
            cyc();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule